// File: doc/BRIEF.md
# Event-Driven Power Domain Sleepwalk Controller

This block sequences three power domains through standby. When the sleep request is seen, it puts every domain that may be gated into retention, stops the peripheral clock and selects the low-power regulator. Domain 2 always goes to retention. Domains 0 and 1 are gated only when their dynamic-gating enable bit is set. Those bits are captured once, at standby entry.

While the block is in standby, an event can be aimed at a peripheral in a retained domain. If the event comes from a source allowed in the current domain arrangement, the block briefly raises that one domain and selects the main regulator. Once both the regulator and the domain report ready, it turns the peripheral clock on so that the peripheral can run one task. The CPU stays asleep throughout. A task-done pulse returns the domain to retention. A peripheral interrupt instead raises every domain and leaves standby. The block then waits for the sleep request to drop before it accepts a new entry.

Top module: `pd_sleepwalk_ctrl`

## Requirements
- R1: After reset, pd_active is 3'b111, main_reg_sel is 1, periph_clk_en is 1 and cpu_asleep is 0.
- R2: When standby_req is seen high while running, the next cycle shows cpu_asleep=1, periph_clk_en=0 and main_reg_sel=0. In that cycle pd_active is {0, ~dyn_gate_en[1], ~dyn_gate_en[0]}, using the enables sampled at that edge. Bit i of pd_active is domain i, and 1 means active.
- R3: A domain whose enable bit was 0 at entry stays active for the whole standby. An event whose ev_dest (0 = domain 0, 1 = domain 1) names an active domain starts no sleepwalk.
- R4: With domain 0 retained, only ev_cmp, ev_rtc, or ev_eic together with eic_ulp_clk=1 start a sleepwalk. ev_eic with eic_ulp_clk=0, and ev_pd0_periph, change nothing.
- R5: With domain 0 left active, ev_rtc, ev_eic with eic_ulp_clk=1, ev_cmp and ev_pd0_periph can each start a sleepwalk of domain 1.
- R6: One cycle after a qualifying event, the target domain's pd_active bit is 1 and main_reg_sel is 1, while periph_clk_en stays 0.
- R7: periph_clk_en rises one cycle after main_reg_ready and pd_ready are both seen high at the same edge. It never rises while only one of them is high.
- R8: A task_done pulse with no periph_irq returns the outputs one cycle later to the standby values of R2.
- R9: periph_irq during the task sets pd_active to 3'b111, main_reg_sel to 1, periph_clk_en to 1 and cpu_asleep to 0 one cycle later. A new standby entry needs standby_req to be seen low first.
- R10: When periph_irq and task_done arrive in the same cycle, the interrupt wins and the block leaves standby.
- R11: Events that arrive during a sleepwalk, whether in the ramp phase or in the task phase, leave every output unchanged.
- R12: cpu_asleep stays 1 from standby entry through every sleepwalk until an interrupt wakes the block.
- R13: Domain 2 is never active while cpu_asleep is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_req | input | 1 | Sleep request from the CPU |
| dyn_gate_en | input | 2 | Per-domain dynamic gating enable for domains 0 and 1 |
| ev_cmp | input | 1 | Comparator event |
| ev_rtc | input | 1 | Real-time-counter event |
| ev_eic | input | 1 | External interrupt controller event |
| eic_ulp_clk | input | 1 | External interrupt controller runs from the 32 kHz ultra-low-power clock |
| ev_pd0_periph | input | 1 | Event from another domain-0 peripheral |
| ev_dest | input | 1 | Domain of the event user (0 or 1) |
| main_reg_ready | input | 1 | Main regulator ready |
| pd_ready | input | 1 | Target domain reports active |
| task_done | input | 1 | One-cycle pulse when the peripheral task ends |
| periph_irq | input | 1 | Interrupt from the sleepwalking peripheral |
| pd_active | output | 3 | Per-domain state, 1 = active, 0 = retention |
| main_reg_sel | output | 1 | 1 = main regulator, 0 = low-power regulator |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_asleep | output | 1 | CPU kept asleep |

## Verification
Task completion and interrupt escalation can fall in the same cycle, because task_done and periph_irq are both sampled in the task phase. The bench provokes this in a directed case and also through random stimulus in which both lines fire independently while a task runs. It judges the result by whether the next cycle shows a full wake with all domains active, rather than a return to retention. A second overlap is also covered: an event can arrive during a sleepwalk that is already running, and the bench confirms that the outputs do not move.

// File: rtl/pd_sw_pkg.sv
// Package: shared state type for the sleepwalk controller.
// Assumes a single controller instance per power manager.
package pd_sw_pkg;
    typedef enum logic [2:0] {
        SW_RUN  = 3'd0,   // all domains active, CPU running
        SW_STBY = 3'd1,   // standby, gated domains retained
        SW_RAMP = 3'd2,   // target domain and main regulator ramping
        SW_TASK = 3'd3,   // peripheral task running, CPU asleep
        SW_WAKE = 3'd4    // woken by interrupt, awaiting request release
    } sw_state_t;
endpackage

// File: rtl/pd_sw_trigger.sv
// Module: decides whether the current event lines start a sleepwalk.
// The allowed sources depend on whether domain 0 is retained. The event
// must target a domain that is retained (its latched enable bit is 1).
// Assumes ev_dest is less than NUM_GATED.
module pd_sw_trigger #(
    parameter int NUM_GATED = 2,
    parameter int DEST_W    = 1
) (
    input  logic [NUM_GATED-1:0] cfg_q,
    input  logic                 ev_cmp,
    input  logic                 ev_rtc,
    input  logic                 ev_eic,
    input  logic                 eic_ulp_clk,
    input  logic                 ev_pd0_periph,
    input  logic [DEST_W-1:0]    ev_dest,
    output logic                 trig
);
    logic src_ok;
    logic dest_gated;

    // Source qualification: domain-0 peripherals count only when domain 0 is awake.
    always_comb begin
        src_ok = ev_cmp | ev_rtc | (ev_eic & eic_ulp_clk)
               | (ev_pd0_periph & ~cfg_q[0]);
    end

    // Destination check: only a retained domain needs waking.
    always_comb begin
        dest_gated = cfg_q[ev_dest];
        trig       = src_ok & dest_gated;
    end
endmodule

// File: rtl/pd_sw_fsm.sv
// Module: sequencing state machine. It latches the gating enables at
// standby entry and the target domain at event time, then walks the
// ramp, task and return (or wake) steps.
// Assumes task_done is a one-cycle pulse; periph_irq beats it on a tie.
module pd_sw_fsm
    import pd_sw_pkg::*;
#(
    parameter int NUM_GATED = 2,
    parameter int DEST_W    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 standby_req,
    input  logic [NUM_GATED-1:0] dyn_gate_en,
    input  logic                 trig,
    input  logic [DEST_W-1:0]    ev_dest,
    input  logic                 main_reg_ready,
    input  logic                 pd_ready,
    input  logic                 task_done,
    input  logic                 periph_irq,
    output sw_state_t            state,
    output logic [NUM_GATED-1:0] cfg_q,
    output logic [DEST_W-1:0]    dom_q
);
    // State, config latch and target latch update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SW_RUN;
            cfg_q <= '0;
            dom_q <= '0;
        end else begin
            case (state)
                SW_RUN: begin
                    if (standby_req) begin
                        state <= SW_STBY;
                        cfg_q <= dyn_gate_en;
                    end
                end
                SW_STBY: begin
                    if (trig) begin
                        state <= SW_RAMP;
                        dom_q <= ev_dest;
                    end
                end
                SW_RAMP: begin
                    if (main_reg_ready && pd_ready) state <= SW_TASK;
                end
                SW_TASK: begin
                    if (periph_irq)     state <= SW_WAKE;
                    else if (task_done) state <= SW_STBY;
                end
                SW_WAKE: begin
                    if (!standby_req) state <= SW_RUN;
                end
                default: state <= SW_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pd_sw_outdec.sv
// Module: decodes state into per-domain state, regulator select, clock
// enable and the CPU sleep flag. Domains above NUM_GATED are always retained
// in standby.
module pd_sw_outdec
    import pd_sw_pkg::*;
#(
    parameter int NUM_PD    = 3,
    parameter int NUM_GATED = 2,
    parameter int DEST_W    = 1
) (
    input  sw_state_t            state,
    input  logic [NUM_GATED-1:0] cfg_q,
    input  logic [DEST_W-1:0]    dom_q,
    output logic [NUM_PD-1:0]    pd_active,
    output logic                 main_reg_sel,
    output logic                 periph_clk_en,
    output logic                 cpu_asleep
);
    logic awake;
    logic sw_on;

    // Phase flags shared by all domain bits.
    always_comb begin
        awake         = (state == SW_RUN) || (state == SW_WAKE);
        sw_on         = (state == SW_RAMP) || (state == SW_TASK);
        main_reg_sel  = awake | sw_on;
        periph_clk_en = awake | (state == SW_TASK);
        cpu_asleep    = ~awake;
    end

    for (genvar i = 0; i < NUM_PD; i++) begin : g_dom
        if (i < NUM_GATED) begin : g_gated
            // Gated domain: active when awake, not enabled, or sleepwalking.
            always_comb begin
                pd_active[i] = awake | ~cfg_q[i]
                             | (sw_on && (dom_q == DEST_W'(i)));
            end
        end else begin : g_fixed
            // Ungated domain: active only when awake.
            always_comb pd_active[i] = awake;
        end
    end
endmodule

// File: rtl/pd_sleepwalk_ctrl.sv
// Top: event-driven sleepwalk controller for the standby power domains.
// Assumes regulator and domain ramps are reported by the ready inputs.
module pd_sleepwalk_ctrl
    import pd_sw_pkg::*;
#(
    parameter int NUM_PD    = 3,
    parameter int NUM_GATED = 2,
    localparam int DEST_W   = (NUM_GATED > 1) ? $clog2(NUM_GATED) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 standby_req,
    input  logic [NUM_GATED-1:0] dyn_gate_en,
    input  logic                 ev_cmp,
    input  logic                 ev_rtc,
    input  logic                 ev_eic,
    input  logic                 eic_ulp_clk,
    input  logic                 ev_pd0_periph,
    input  logic [DEST_W-1:0]    ev_dest,
    input  logic                 main_reg_ready,
    input  logic                 pd_ready,
    input  logic                 task_done,
    input  logic                 periph_irq,
    output logic [NUM_PD-1:0]    pd_active,
    output logic                 main_reg_sel,
    output logic                 periph_clk_en,
    output logic                 cpu_asleep
);
    sw_state_t            state;
    logic [NUM_GATED-1:0] cfg_q;
    logic [DEST_W-1:0]    dom_q;
    logic                 trig;

    pd_sw_trigger #(.NUM_GATED(NUM_GATED), .DEST_W(DEST_W)) u_trig (
        .cfg_q(cfg_q), .ev_cmp(ev_cmp), .ev_rtc(ev_rtc), .ev_eic(ev_eic),
        .eic_ulp_clk(eic_ulp_clk), .ev_pd0_periph(ev_pd0_periph),
        .ev_dest(ev_dest), .trig(trig)
    );

    pd_sw_fsm #(.NUM_GATED(NUM_GATED), .DEST_W(DEST_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .standby_req(standby_req),
        .dyn_gate_en(dyn_gate_en), .trig(trig), .ev_dest(ev_dest),
        .main_reg_ready(main_reg_ready), .pd_ready(pd_ready),
        .task_done(task_done), .periph_irq(periph_irq),
        .state(state), .cfg_q(cfg_q), .dom_q(dom_q)
    );

    pd_sw_outdec #(.NUM_PD(NUM_PD), .NUM_GATED(NUM_GATED), .DEST_W(DEST_W)) u_dec (
        .state(state), .cfg_q(cfg_q), .dom_q(dom_q), .pd_active(pd_active),
        .main_reg_sel(main_reg_sel), .periph_clk_en(periph_clk_en),
        .cpu_asleep(cpu_asleep)
    );
endmodule

// File: rtl/pd_sw_checker.sv
// Checker: temporal properties on the controller ports, bound to the top.
module pd_sw_checker #(
    parameter int NUM_PD = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              main_reg_ready,
    input logic              pd_ready,
    input logic              task_done,
    input logic              periph_irq,
    input logic [NUM_PD-1:0] pd_active,
    input logic              main_reg_sel,
    input logic              periph_clk_en,
    input logic              cpu_asleep
);
    // R7
    clk_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_asleep && $rose(periph_clk_en)) |-> $past(main_reg_ready && pd_ready));

    // R13
    top_dom_retained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_asleep |-> !pd_active[NUM_PD-1]);

    // R6
    task_on_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_asleep && periph_clk_en) |-> main_reg_sel);

    // R9
    wake_all_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_asleep) |-> (pd_active == {NUM_PD{1'b1}}));

    // R10
    irq_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_asleep && periph_clk_en && periph_irq && task_done) |=> !cpu_asleep);
endmodule

bind pd_sleepwalk_ctrl pd_sw_checker #(.NUM_PD(NUM_PD)) u_chk (
    .clk(clk), .rst_n(rst_n), .main_reg_ready(main_reg_ready),
    .pd_ready(pd_ready), .task_done(task_done), .periph_irq(periph_irq),
    .pd_active(pd_active), .main_reg_sel(main_reg_sel),
    .periph_clk_en(periph_clk_en), .cpu_asleep(cpu_asleep)
);

// File: tb/pd_sleepwalk_ctrl_tb.sv
module pd_sleepwalk_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_req = 1'b0;
    logic [1:0] dyn_gate_en = 2'b00;
    logic       ev_cmp = 1'b0, ev_rtc = 1'b0, ev_eic = 1'b0, eic_ulp_clk = 1'b0;
    logic       ev_pd0_periph = 1'b0;
    logic [0:0] ev_dest = 1'b0;
    logic       main_reg_ready = 1'b0, pd_ready = 1'b0;
    logic       task_done = 1'b0, periph_irq = 1'b0;
    logic [2:0] pd_active;
    logic       main_reg_sel, periph_clk_en, cpu_asleep;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench model: 0 run, 1 standby, 2 ramp, 3 task, 4 woken.
    int         m_st = 0;
    logic [1:0] m_cfg = 2'b00;
    logic       m_dom = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pd_sleepwalk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .standby_req(standby_req),
        .dyn_gate_en(dyn_gate_en), .ev_cmp(ev_cmp), .ev_rtc(ev_rtc),
        .ev_eic(ev_eic), .eic_ulp_clk(eic_ulp_clk),
        .ev_pd0_periph(ev_pd0_periph), .ev_dest(ev_dest),
        .main_reg_ready(main_reg_ready), .pd_ready(pd_ready),
        .task_done(task_done), .periph_irq(periph_irq),
        .pd_active(pd_active), .main_reg_sel(main_reg_sel),
        .periph_clk_en(periph_clk_en), .cpu_asleep(cpu_asleep)
    );

    function automatic logic trig_ok();
        logic src;
        src = ev_cmp | ev_rtc | (ev_eic & eic_ulp_clk) | (ev_pd0_periph & ~m_cfg[0]);
        return src & m_cfg[ev_dest];
    endfunction

    function automatic logic [2:0] exp_pd();
        logic [2:0] v;
        if (m_st == 0 || m_st == 4) return 3'b111;
        v = {1'b0, ~m_cfg[1], ~m_cfg[0]};
        if (m_st == 2 || m_st == 3) v[m_dom] = 1'b1;
        return v;
    endfunction

    task automatic model_step();
        case (m_st)
            0: if (standby_req) begin m_st = 1; m_cfg = dyn_gate_en; end
            1: if (trig_ok()) begin m_st = 2; m_dom = ev_dest[0]; end
            2: if (main_reg_ready && pd_ready) m_st = 3;
            3: if (periph_irq) m_st = 4; else if (task_done) m_st = 1;
            default: if (!standby_req) m_st = 0;
        endcase
    endtask

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic awake;
        awake = (m_st == 0 || m_st == 4);
        chk({tag, " pd_active"}, pd_active, exp_pd());
        chk({tag, " main_reg_sel"}, {2'b0, main_reg_sel}, {2'b0, ~(m_st == 1)});
        chk({tag, " periph_clk_en"}, {2'b0, periph_clk_en}, {2'b0, awake || m_st == 3});
        chk({tag, " cpu_asleep"}, {2'b0, cpu_asleep}, {2'b0, ~awake});
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clr_ev();
        ev_cmp = 0; ev_rtc = 0; ev_eic = 0; ev_pd0_periph = 0;
        task_done = 0; periph_irq = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        chk("R1 pd_active literal", pd_active, 3'b111);

        // Both domains gated, standby entry.
        dyn_gate_en = 2'b11; standby_req = 1;
        cyc("R2 entry");
        chk("R2 pd_active literal", pd_active, 3'b000);
        dyn_gate_en = 2'b00;            // must not matter after entry
        ev_eic = 1; eic_ulp_clk = 0;
        cyc("R4 eic without ulp clock");
        clr_ev(); ev_pd0_periph = 1;
        cyc("R4 pd0 periph while domain 0 retained");
        clr_ev(); ev_rtc = 1; ev_dest = 0;
        cyc("R6 rtc wakes domain 0");
        chk("R6 pd_active literal", pd_active, 3'b001);
        clr_ev(); ev_cmp = 1; ev_dest = 1;
        cyc("R11 event during ramp");
        clr_ev(); main_reg_ready = 1;
        cyc("R7 only regulator ready");
        main_reg_ready = 0; pd_ready = 1;
        cyc("R7 only domain ready");
        main_reg_ready = 1;
        cyc("R7 both ready");
        chk("R7 clock enable literal", {2'b0, periph_clk_en}, 3'b001);
        ev_rtc = 1; ev_dest = 1;
        cyc("R11 event during task");
        clr_ev(); task_done = 1;
        cyc("R8 done returns to retention");
        chk("R8 pd_active literal", pd_active, 3'b000);
        clr_ev(); ev_eic = 1; eic_ulp_clk = 1; ev_dest = 1;
        cyc("R4 eic on ulp clock wakes domain 1");
        chk("R4 pd_active literal", pd_active, 3'b010);
        clr_ev();
        cyc("R12 task starts");
        task_done = 1; periph_irq = 1;
        cyc("R10 irq beats done");
        chk("R10 pd_active literal", pd_active, 3'b111);
        clr_ev();
        cyc("R9 held request stays awake");
        standby_req = 0;
        cyc("R9 request released");

        // Domain 0 left active.
        dyn_gate_en = 2'b10; standby_req = 1;
        cyc("R3 entry with domain 0 ungated");
        chk("R3 pd_active literal", pd_active, 3'b001);
        ev_pd0_periph = 1; ev_dest = 0;
        cyc("R3 event to active domain ignored");
        ev_dest = 1;
        cyc("R5 pd0 periph wakes domain 1");
        chk("R5 pd_active literal", pd_active, 3'b011);
        clr_ev();
        cyc("R12 ramp to task");
        task_done = 1;
        cyc("R13 back to standby");
        clr_ev();

        // Constrained random phase.
        for (int i = 0; i < 3000; i++) begin
            standby_req    = ($urandom % 10) != 0;
            if (m_st == 0) dyn_gate_en = 2'($urandom);
            ev_cmp         = ($urandom % 8) == 0;
            ev_rtc         = ($urandom % 8) == 0;
            ev_eic         = ($urandom % 6) == 0;
            eic_ulp_clk    = 1'($urandom);
            ev_pd0_periph  = ($urandom % 6) == 0;
            ev_dest        = 1'($urandom);
            main_reg_ready = 1'($urandom);
            pd_ready       = 1'($urandom);
            task_done      = ($urandom % 4) == 0;
            periph_irq     = ($urandom % 12) == 0;
            cyc("R12 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule